// File: doc/BRIEF.md
# Serial Flash Status Write Controller

This block is the command decoder on the slave side of a serial flash device that deals with writes to the status byte. The host selects the device by pulling chip select low. It then clocks serial data in, most significant bit first, and each bit is captured on a rising serial clock edge. Only two commands are recognised. The first arms a write-enable flag. The second carries one data byte that sets a protection lock bit and may request a device-wide protect or unprotect of every sector.

The serial side holds a bit counter and a shift register. Both are cleared asynchronously while chip select is high. Opcode and data fields are captured as they complete. The system-clock side synchronises chip select and detects its rising edge, and only at that edge does it act on the frame just received. The write-enable flag and the lock bit therefore never change while a frame is being shifted. An active-low guard input prevents the lock bit from being cleared. It does not prevent the lock bit from being set. The global protect and unprotect requests are single system-clock pulses. Whether either pulse fires depends on the lock value held before the command.

Top module: `flash_stat_wr`

## Requirements
- R1: After reset the lock bit and the write-enable flag are 0, and neither request pulse is active.
- R2: Opcode 8'h06 that is followed by exactly 8 clock edges before chip select rises sets the write-enable flag. The same opcode followed by any further bits leaves the flag unchanged.
- R3: Opcode 8'h01 while the write-enable flag is 0 changes nothing: the lock stays, no pulse fires and the flag stays 0.
- R4: Opcode 8'h01 while the write-enable flag is 1, followed by a full data byte, loads data bit 7 into the lock bit and clears the write-enable flag. Data bits 6, 1 and 0 have no effect.
- R5: If chip select rises after opcode 8'h01 but before all 8 data bits have arrived, the lock bit is kept and no pulse fires. The write-enable flag is still cleared.
- R6: While the guard input is low, an 8'h01 command whose data bit 7 is 0 is dropped as a whole: the lock is kept and no pulse fires. The write-enable flag is still cleared. With data bit 7 equal to 1 the command proceeds.
- R7: A command that R4 accepts, with a prior lock of 0, issues one system-clock protect pulse if data bits 5..2 are 4'b1111, or one unprotect pulse if they are 4'b0000. No pulse is issued for any other code, or when the prior lock is 1.
- R8: Bytes clocked in after the first data byte of an 8'h01 command are ignored.
- R9: Any other opcode leaves the lock bit and the write-enable flag unchanged when chip select rises.
- R10: Outputs hold their values while chip select is low. A select with no clock edges changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock; data captured on its rising edge |
| si | input | 1 | Serial data in, MSB first |
| wr_guard_n | input | 1 | Active-low guard that blocks clearing the lock |
| lock_o | output | 1 | Current protection lock bit |
| wen_o | output | 1 | Current write-enable flag |
| all_prot_o | output | 1 | One-cycle global protect request |
| all_unprot_o | output | 1 | One-cycle global unprotect request |

## Verification
The assertions assume that chip select stays high for several system clocks after it rises, long enough for the synchronised edge to be seen and the commit to complete. They also assume that the guard input is held steady from before a frame until its commit. The bench drives every frame this way. It sets the guard first, leaves gaps between serial edges that are several system clocks wide, and waits ten system clocks with chip select high before it checks the outputs or starts another frame. No serial clock edge is ever given while chip select is high.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  localparam int OP_W     = 8;
  localparam int CODE_W   = 4;
  localparam int LOCK_POS = 7;
  localparam int CODE_HI  = 5;
  localparam int CODE_LO  = 2;
  localparam logic [OP_W-1:0]   OP_WR_ENABLE = 8'h06;
  localparam logic [OP_W-1:0]   OP_STAT_WR   = 8'h01;
  localparam logic [CODE_W-1:0] CODE_ALL_ON  = 4'hF;
  localparam logic [CODE_W-1:0] CODE_ALL_OFF = 4'h0;
endpackage

// File: rtl/sfw_sync.sv
module sfw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb pipe_d = d;
    end else begin : g_many
      always_comb pipe_d = {pipe_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/sfw_rx.sv
module sfw_rx
  import sfw_pkg::*;
(
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic [OP_W-1:0]   opc_o,
  output logic              op_full_o,
  output logic              op_over_o,
  output logic              dat_full_o,
  output logic              lock_o,
  output logic [CODE_W-1:0] code_o,
  output logic              tog_o
);
  localparam int CNT_W = $clog2(2*OP_W+2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(2*OP_W+1);
  localparam logic [CNT_W-1:0] OP_LAST  = CNT_W'(OP_W-1);
  localparam logic [CNT_W-1:0] OP_NEXT  = CNT_W'(OP_W);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(2*OP_W-1);

  logic             clr;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OP_W-2:0]  sh_q;
  logic [OP_W-1:0]  byte_w;

  assign clr    = cs_n | ~rst_n;
  assign byte_w = {sh_q, si};

  always_comb begin
    if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                  cnt_d = cnt_q + 1'b1;
  end

  // Frame position: cleared whenever the device is not selected.
  always_ff @(posedge sck or posedge clr) begin
    if (clr) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= byte_w[OP_W-2:0];
    end
  end

  // Captured fields: held across the deselect so the commit side can read them.
  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      opc_o      <= '0;
      op_full_o  <= 1'b0;
      op_over_o  <= 1'b0;
      dat_full_o <= 1'b0;
      lock_o     <= 1'b0;
      code_o     <= '0;
      tog_o      <= 1'b0;
    end else if (!cs_n) begin
      if (cnt_q == '0) begin
        tog_o      <= ~tog_o;
        op_full_o  <= 1'b0;
        op_over_o  <= 1'b0;
        dat_full_o <= 1'b0;
      end
      if (cnt_q == OP_LAST) begin
        opc_o     <= byte_w;
        op_full_o <= 1'b1;
      end
      if (cnt_q == OP_NEXT) op_over_o <= 1'b1;
      if (cnt_q == DAT_LAST) begin
        lock_o     <= byte_w[LOCK_POS];
        code_o     <= byte_w[CODE_HI:CODE_LO];
        dat_full_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfw_commit.sv
module sfw_commit
  import sfw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              guard_s,
  input  logic [OP_W-1:0]   opc,
  input  logic              op_full,
  input  logic              op_over,
  input  logic              dat_full,
  input  logic              new_lock,
  input  logic [CODE_W-1:0] code,
  input  logic              tog,
  output logic              lock_o,
  output logic              wen_o,
  output logic              all_prot_o,
  output logic              all_unprot_o
);
  logic cs_prev_q, seen_q, lock_q, wen_q, on_q, off_q;
  logic seen_d, lock_d, wen_d, on_d, off_d;
  logic fire, blocked;

  always_comb begin
    fire    = cs_s & ~cs_prev_q & (tog != seen_q);
    blocked = ~guard_s & ~new_lock;
    seen_d  = seen_q;
    lock_d  = lock_q;
    wen_d   = wen_q;
    on_d    = 1'b0;
    off_d   = 1'b0;
    if (fire) begin
      seen_d = tog;
      if (op_full && opc == OP_WR_ENABLE && !op_over) begin
        wen_d = 1'b1;
      end else if (op_full && opc == OP_STAT_WR && wen_q) begin
        wen_d = 1'b0;
        if (dat_full && !blocked) begin
          lock_d = new_lock;
          if (!lock_q) begin
            on_d  = (code == CODE_ALL_ON);
            off_d = (code == CODE_ALL_OFF);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q <= 1'b1;
      seen_q    <= 1'b0;
      lock_q    <= 1'b0;
      wen_q     <= 1'b0;
      on_q      <= 1'b0;
      off_q     <= 1'b0;
    end else begin
      cs_prev_q <= cs_s;
      seen_q    <= seen_d;
      lock_q    <= lock_d;
      wen_q     <= wen_d;
      on_q      <= on_d;
      off_q     <= off_d;
    end
  end

  assign lock_o       = lock_q;
  assign wen_o        = wen_q;
  assign all_prot_o   = on_q;
  assign all_unprot_o = off_q;
endmodule

// File: rtl/flash_stat_wr.sv
module flash_stat_wr
  import sfw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wr_guard_n,
  output logic lock_o,
  output logic wen_o,
  output logic all_prot_o,
  output logic all_unprot_o
);
  logic [OP_W-1:0]   opc;
  logic [CODE_W-1:0] code;
  logic op_full, op_over, dat_full, new_lock, tog, cs_s, guard_s;

  sfw_rx u_rx (
    .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .opc_o(opc), .op_full_o(op_full), .op_over_o(op_over),
    .dat_full_o(dat_full), .lock_o(new_lock), .code_o(code), .tog_o(tog)
  );

  sfw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s)
  );

  sfw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_guard_sync (
    .clk(clk), .rst_n(rst_n), .d(wr_guard_n), .q(guard_s)
  );

  sfw_commit u_commit (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .guard_s(guard_s),
    .opc(opc), .op_full(op_full), .op_over(op_over), .dat_full(dat_full),
    .new_lock(new_lock), .code(code), .tog(tog),
    .lock_o(lock_o), .wen_o(wen_o),
    .all_prot_o(all_prot_o), .all_unprot_o(all_unprot_o)
  );
endmodule

// File: rtl/flash_stat_wr_chk.sv
module flash_stat_wr_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic wr_guard_n,
  input logic lock_o,
  input logic wen_o,
  input logic all_prot_o,
  input logic all_unprot_o
);
  assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(all_prot_o && all_unprot_o));

  assert_prot_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    all_prot_o |=> !all_prot_o);

  assert_unprot_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    all_unprot_o |=> !all_unprot_o);

  assert_pulse_prior_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (all_prot_o || all_unprot_o) |-> !$past(lock_o));

  assert_pulse_needs_wen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (all_prot_o || all_unprot_o) |-> ($past(wen_o) && !wen_o));

  assert_lock_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o != $past(lock_o)) |-> ($past(wen_o) && !wen_o));

  assert_guard_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> wr_guard_n);

  assert_quiet_while_selected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((wen_o != $past(wen_o)) || (lock_o != $past(lock_o))) |-> (cs_n && $past(cs_n)));
endmodule

bind flash_stat_wr flash_stat_wr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_guard_n(wr_guard_n),
  .lock_o(lock_o), .wen_o(wen_o),
  .all_prot_o(all_prot_o), .all_unprot_o(all_unprot_o)
);

// File: tb/flash_stat_wr_test.sv
module flash_stat_wr_test;
  localparam int CLK_P = 10;
  localparam int SCK_H = 20;

  logic clk, rst_n, cs_n, sck, si, wr_guard_n;
  logic lock_o, wen_o, all_prot_o, all_unprot_o;
  int n_run, n_fail, n_on, n_off;
  bit done;
  logic m_lock, m_wen;

  flash_stat_wr uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .wr_guard_n(wr_guard_n), .lock_o(lock_o), .wen_o(wen_o),
    .all_prot_o(all_prot_o), .all_unprot_o(all_unprot_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (all_prot_o)   n_on  = n_on + 1;
    if (all_unprot_o) n_off = n_off + 1;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [23:0] frm, input int nbits, input logic guard);
    string tag;
    logic [7:0] op;
    logic nl;
    logic [3:0] cd;
    int e_on, e_off;
    logic pre_lock, pre_wen;
    op = frm[23:16]; nl = frm[15]; cd = frm[13:10];
    e_on = 0; e_off = 0;
    pre_lock = m_lock; pre_wen = m_wen;
    if (nbits < 8) tag = "R10";
    else if (op == 8'h06) begin
      tag = "R2";
      if (nbits == 8) m_wen = 1'b1;
    end else if (op != 8'h01) tag = "R9";
    else if (!m_wen) tag = "R3";
    else begin
      m_wen = 1'b0;
      if (nbits < 16) tag = "R5";
      else if (!guard && !nl) tag = "R6";
      else begin
        tag = (nbits > 16) ? "R8" : "R4";
        if (!m_lock) begin
          e_on  = (cd == 4'hF) ? 1 : 0;
          e_off = (cd == 4'h0) ? 1 : 0;
        end
        m_lock = nl;
      end
    end
    wr_guard_n = guard;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    #(SCK_H);
    for (int i = 0; i < nbits; i++) begin
      si = frm[23-i];
      #(SCK_H) sck = 1'b1;
      #(SCK_H) sck = 1'b0;
    end
    @(negedge clk);
    chk("R10", "lock while selected", int'(lock_o), int'(pre_lock));
    chk("R10", "wen while selected", int'(wen_o), int'(pre_wen));
    n_on = 0; n_off = 0;
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(tag, "lock", int'(lock_o), int'(m_lock));
    chk(tag, "wen", int'(wen_o), int'(m_wen));
    chk("R7", "protect pulses", n_on, e_on);
    chk("R7", "unprotect pulses", n_off, e_off);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; n_on = 0; n_off = 0; done = 1'b0;
    cs_n = 1'b1; sck = 1'b0; si = 1'b0; wr_guard_n = 1'b1; rst_n = 1'b0;
    m_lock = 1'b0; m_wen = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "reset lock", int'(lock_o), 0);
    chk("R1", "reset wen", int'(wen_o), 0);
    chk("R1", "reset protect", int'(all_prot_o), 0);
    chk("R1", "reset unprotect", int'(all_unprot_o), 0);

    run_frame({8'h01, 8'h80, 8'h00}, 16, 1'b1);   // R3: no enable yet
    run_frame({8'h06, 16'h0000}, 9, 1'b1);        // R2: too long
    run_frame({8'h06, 16'h0000}, 8, 1'b1);        // R2: sets flag
    run_frame({8'h05, 16'h0000}, 8, 1'b1);        // R9: unknown opcode
    run_frame({8'h9F, 16'h0000}, 16, 1'b1);       // R9
    run_frame(24'h0, 0, 1'b1);                    // R10: empty select
    run_frame({8'h01, 8'hBC, 8'h00}, 12, 1'b1);   // R5: aborted data
    run_frame({8'h06, 16'h0000}, 8, 1'b1);
    run_frame({8'h01, 8'hBC, 8'h00}, 15, 1'b1);   // R5: one bit short

    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 2; p++)
        for (int c = 0; c < 16; c++)
          for (int b = 0; b < 2; b++) begin
            logic [7:0] d;
            run_frame({8'h06, 16'h0000}, 8, 1'b1);
            run_frame({8'h01, 1'(p), 7'h14, 8'h00}, 16, 1'b1);
            run_frame({8'h06, 16'h0000}, 8, 1'b1);
            d = {1'(b), 1'(c), 4'(c), ~2'(c)};
            run_frame({8'h01, d, 8'h5A}, (c % 3 == 0) ? 24 : 16, 1'(g));
          end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule